// File: doc/BRIEF.md
# Watchdog Second-Chance Reset Path

This block drives the reset that leaves the watchdog for the rest of the system. It has two sources. The first is the reset request from the watchdog's exception logic, which runs on the bus clock. The block brings that request into the watchdog clock domain through a synchroniser and turns its rising edge into a reset pulse.

The second source is a backup path that runs only on the watchdog clock. It counts timeout pulses and clears the count whenever a system reset is reported. The exception logic should normally answer the first timeout. If a second timeout arrives with no system reset in between, the bus-clocked logic is taken to have stalled, and the backup path drives the reset itself. This path has no dependence on the bus clock, so a stopped bus clock cannot hold back the reset.

Every trigger from either source produces a reset pulse of fixed length on the watchdog clock. A new trigger that arrives while a pulse is still running restarts the pulse at full length.

Top module: `wdog_backup_rst`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sys_rst_out` is low after that edge. This holds even when a pulse was running. Leaving reset, the timeout count is zero.
- R2: A timeout pulse that arrives when the count is zero does not assert `sys_rst_out`. It raises the count to one.
- R3: A timeout pulse that arrives when the count is at least one, with `sys_rst_seen` low, asserts `sys_rst_out` from the clock edge that samples it.
- R4: Once triggered, `sys_rst_out` stays high for exactly `PULSE_LEN` (default 4) clock cycles and then returns low, unless a new trigger arrives.
- R5: `sys_rst_seen` high at a clock edge clears the count to zero. The next timeout is then treated as the first.
- R6: The count saturates at `FIRE_COUNT` (default 2). Every further timeout without a clear triggers a reset pulse again.
- R7: A rising edge on `main_rst_req` asserts `sys_rst_out` at the third clock edge after the request is first sampled high. This delay comes from two synchroniser stages plus one edge-detect stage. Holding the request high gives a single pulse only.
- R8: A trigger during an active pulse reloads the pulse. The output then stays high for `PULSE_LEN` cycles counted from the new trigger's edge.
- R9: When `sys_rst_seen` and a timeout are high at the same edge, the clear wins. No pulse is started and the count becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_wd | input | 1 | Watchdog clock; every register in the block runs on it |
| rst_n | input | 1 | Synchronous active-low reset, watchdog clock domain |
| main_rst_req | input | 1 | Reset request from the bus-clocked exception logic (asynchronous to clk_wd) |
| timeout_pulse | input | 1 | One-cycle timeout strobe, watchdog clock domain |
| sys_rst_seen | input | 1 | High for at least one cycle when a system reset has occurred, watchdog clock domain |
| sys_rst_out | output | 1 | Active-high system reset, registered |

## Verification
The assertions assume that `timeout_pulse` and `sys_rst_seen` are already synchronous to `clk_wd`. They also assume that `main_rst_req` changes no faster than the synchroniser can follow, so every level it takes lasts at least two watchdog cycles. The bench drives every input on the falling edge of the watchdog clock. It holds each main request level for many cycles and gives each timeout as a single-cycle strobe. This keeps the stimulus within what the properties take as given and matches how a real timeout counter and reset monitor behave.

// File: rtl/wbr_pkg.sv
// Package: shared defaults and width helper for the second-chance reset path.
// Assumes: all users size their counters from wbr_width so the widths agree.
package wbr_pkg;

    localparam int unsigned WBR_SYNC_STAGES = 2;
    localparam int unsigned WBR_PULSE_LEN   = 4;
    localparam int unsigned WBR_FIRE_COUNT  = 2;

    // Number of bits needed to hold the values 0..v inclusive.
    function automatic int unsigned wbr_width(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/wbr_sync.sv
// Module: multi-stage level synchroniser followed by a rising-edge detector.
// Assumes: d_async holds each level for at least STAGES destination cycles;
// STAGES >= 2. rise_o is a one-cycle strobe in the destination domain.
module wbr_sync #(
    parameter int unsigned STAGES = wbr_pkg::WBR_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic rise_o
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    // Stage 0 captures the asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d_async;
    end

    // Further stages settle any metastability.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    // Remembers the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise_o = chain[STAGES-1] & ~last_q;

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);  // R7

endmodule

// File: rtl/wbr_to_count.sv
// Module: saturating timeout counter for the backup path.
// A timeout that finds the count at FIRE_COUNT-1 or more fires the backup
// reset. A system-reset indication clears the count and wins over a timeout.
// Assumes: timeout_i and clear_i are synchronous to clk.
module wbr_to_count #(
    parameter int unsigned FIRE_COUNT = wbr_pkg::WBR_FIRE_COUNT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout_i,
    input  logic clear_i,
    output logic fire_o
);

    localparam int unsigned CW = wbr_pkg::wbr_width(FIRE_COUNT);
    localparam logic [CW-1:0] SAT_VAL   = CW'(FIRE_COUNT);
    localparam logic [CW-1:0] ARMED_VAL = CW'(FIRE_COUNT - 1);

    logic [CW-1:0] cnt_q;
    logic          armed;

    assign armed  = (cnt_q >= ARMED_VAL);
    assign fire_o = timeout_i & ~clear_i & armed;

    // Count timeouts up to saturation; clear on system reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (clear_i)                        cnt_q <= '0;
        else if (timeout_i && (cnt_q < SAT_VAL)) cnt_q <= cnt_q + CW'(1);
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT_VAL);  // R6
    AST_CLEAR_ZEROES:  assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));  // R5
    AST_CNT_HOLDS:     assert property (@(posedge clk) disable iff (!rst_n)
        (!timeout_i && !clear_i) |=> $stable(cnt_q));  // R2
    AST_FIRST_COUNTS:  assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i && !clear_i && cnt_q == '0) |=> (cnt_q == CW'(1)));  // R2

endmodule

// File: rtl/wbr_stretch.sv
// Module: fixed-length pulse generator with reload.
// Any trigger loads LEN; the output is high while the remaining count is
// non-zero. Output is registered.
// Assumes: LEN >= 1.
module wbr_stretch #(
    parameter int unsigned LEN = wbr_pkg::WBR_PULSE_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic out_o
);

    localparam int unsigned RW = wbr_pkg::wbr_width(LEN);
    localparam logic [RW-1:0] LEN_VAL = RW'(LEN);

    logic [RW-1:0] rem_q;
    logic [RW-1:0] rem_d;

    // Next remaining count: reload on trigger, else count down to zero.
    always_comb begin
        if (trig_i)              rem_d = LEN_VAL;
        else if (rem_q != '0)    rem_d = rem_q - RW'(1);
        else                     rem_d = '0;
    end

    // Remaining-cycle register and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            out_o <= 1'b0;
        end else begin
            rem_q <= rem_d;
            out_o <= (rem_d != '0);
        end
    end

    AST_TRIG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (out_o && rem_q == LEN_VAL));  // R8
    AST_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && rem_q != '0) |=> (rem_q == $past(rem_q) - RW'(1)));  // R4
    AST_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && !out_o) |=> !out_o);  // R4

endmodule

// File: rtl/wdog_backup_rst.sv
// Module: final system-reset driver for the watchdog.
// It ORs the synchronised main reset request with the backup timeout path and
// stretches either trigger to a fixed pulse on the watchdog clock.
// Assumes: timeout_pulse and sys_rst_seen are in the clk_wd domain;
// main_rst_req is asynchronous and holds its levels for several cycles.
module wdog_backup_rst #(
    parameter int unsigned SYNC_STAGES = wbr_pkg::WBR_SYNC_STAGES,
    parameter int unsigned FIRE_COUNT  = wbr_pkg::WBR_FIRE_COUNT,
    parameter int unsigned PULSE_LEN   = wbr_pkg::WBR_PULSE_LEN
) (
    input  logic clk_wd,
    input  logic rst_n,
    input  logic main_rst_req,
    input  logic timeout_pulse,
    input  logic sys_rst_seen,
    output logic sys_rst_out
);

    logic main_rise;
    logic backup_fire;
    logic any_trig;

    wbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_wd),
        .rst_n   (rst_n),
        .d_async (main_rst_req),
        .rise_o  (main_rise)
    );

    wbr_to_count #(.FIRE_COUNT(FIRE_COUNT)) u_count (
        .clk       (clk_wd),
        .rst_n     (rst_n),
        .timeout_i (timeout_pulse),
        .clear_i   (sys_rst_seen),
        .fire_o    (backup_fire)
    );

    assign any_trig = main_rise | backup_fire;

    wbr_stretch #(.LEN(PULSE_LEN)) u_stretch (
        .clk    (clk_wd),
        .rst_n  (rst_n),
        .trig_i (any_trig),
        .out_o  (sys_rst_out)
    );

    AST_MAIN_DRIVES:   assert property (@(posedge clk_wd) disable iff (!rst_n)
        main_rise |=> sys_rst_out);  // R7
    AST_BACKUP_DRIVES: assert property (@(posedge clk_wd) disable iff (!rst_n)
        backup_fire |=> sys_rst_out);  // R3
    AST_CLEAR_BLOCKS:  assert property (@(posedge clk_wd) disable iff (!rst_n)
        (sys_rst_seen && !main_rise && !sys_rst_out) |=> !sys_rst_out);  // R9

endmodule

// File: tb/wdog_backup_rst_bench.sv
module wdog_backup_rst_bench;

    logic clk_wd = 1'b0;
    logic rst_n;
    logic main_rst_req;
    logic timeout_pulse;
    logic sys_rst_seen;
    logic sys_rst_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk_wd = ~clk_wd;   // 200 MHz

    wdog_backup_rst u_wdog_backup_rst (
        .clk_wd        (clk_wd),
        .rst_n         (rst_n),
        .main_rst_req  (main_rst_req),
        .timeout_pulse (timeout_pulse),
        .sys_rst_seen  (sys_rst_seen),
        .sys_rst_out   (sys_rst_out)
    );

    // Vector bits: {timeout, seen, expected output before driving, req tag}
    // Walked one per falling edge: check expected, then drive stimulus.
    localparam int NV = 29;
    localparam logic [2:0] VEC [0:NV-1] = '{
        3'b100, // 0  first timeout (R2)
        3'b000, // 1
        3'b100, // 2  second timeout fires (R3)
        3'b001, // 3  pulse 1 (R4)
        3'b001, // 4
        3'b001, // 5
        3'b001, // 6
        3'b010, // 7  ended (R4); system reset seen (R5)
        3'b100, // 8  after clear -> first again (R5)
        3'b000, // 9
        3'b100, // 10 second fires
        3'b001, // 11
        3'b101, // 12 third timeout while active: saturate, reload (R6, R8)
        3'b001, // 13
        3'b001, // 14
        3'b001, // 15
        3'b001, // 16
        3'b110, // 17 ended; timeout with seen together (R9)
        3'b100, // 18 count was cleared -> first (R9)
        3'b000, // 19
        3'b100, // 20 second fires
        3'b011, // 21 seen during pulse
        3'b001, // 22
        3'b001, // 23
        3'b001, // 24
        3'b100, // 25 ended; count cleared -> first, silent (R5)
        3'b000, // 26
        3'b010, // 27
        3'b000  // 28
    };
    localparam string VTAG [0:NV-1] = '{
        "R1","R2","R2","R3","R4","R4","R4","R4","R5","R5","R5","R3",
        "R6","R8","R8","R8","R8","R8","R9","R9","R9","R3","R4","R4",
        "R4","R4","R5","R5","R5"};

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sys_rst_out=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        rst_n = 1'b0; main_rst_req = 1'b0; timeout_pulse = 1'b0; sys_rst_seen = 1'b0;
        repeat (3) @(negedge clk_wd);
        check(sys_rst_out, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk_wd);

        // Table walk (R2..R6, R8, R9)
        for (int i = 0; i < NV; i++) begin
            check(sys_rst_out, VEC[i][0], VTAG[i]);
            timeout_pulse = VEC[i][2];
            sys_rst_seen  = VEC[i][1];
            @(negedge clk_wd);
            timeout_pulse = 1'b0;
            sys_rst_seen  = 1'b0;
        end

        // Main path latency and single pulse for a held request (R7)
        repeat (3) @(negedge clk_wd);
        main_rst_req = 1'b1;
        @(negedge clk_wd); check(sys_rst_out, 1'b0, "R7");
        @(negedge clk_wd); check(sys_rst_out, 1'b0, "R7");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk_wd); check(sys_rst_out, 1'b1, "R7");
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk_wd); check(sys_rst_out, 1'b0, "R7");
        end
        main_rst_req = 1'b0;
        repeat (4) @(negedge clk_wd);

        // Count not left at zero should stay silent for one timeout: clear first
        sys_rst_seen = 1'b1; @(negedge clk_wd); sys_rst_seen = 1'b0;
        timeout_pulse = 1'b1; @(negedge clk_wd); timeout_pulse = 1'b0;
        @(negedge clk_wd); check(sys_rst_out, 1'b0, "R2");

        // Reset during an active pulse drops the output and clears the count (R1)
        timeout_pulse = 1'b1; @(negedge clk_wd); timeout_pulse = 1'b0;
        check(sys_rst_out, 1'b1, "R3");
        rst_n = 1'b0; @(negedge clk_wd);
        check(sys_rst_out, 1'b0, "R1");
        rst_n = 1'b1; @(negedge clk_wd);
        timeout_pulse = 1'b1; @(negedge clk_wd); timeout_pulse = 1'b0;
        @(negedge clk_wd); check(sys_rst_out, 1'b0, "R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk_wd);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule